// File: doc/BRIEF.md
# Column-Addressed Two-Bit Random-Access Scan Array

This block is a grid of scan storage cells laid out as rows and columns. There is one row for each parallel scan chain. A binary column address picks one column at a time. A scan write then loads one bit per chain into every cell of that column together. A scan read of the addressed column returns its bits on the scan-out word in the same cycle. Only the addressed column's cells are clock-enabled on a write. Every other column holds its contents, which keeps switching on the scan path low.

Each cell keeps two bits. The shadow bit receives scan data. The functional bit drives the logic under test. Because scan writes touch only the shadow bit, a pattern can be staged while the logic keeps seeing a steady value. An apply pulse moves all shadow bits into the functional bits in one cycle. A capture pulse loads the functional response into every cell at once, so capture never depends on a neighbouring cell's order.

Together these operations give a two-pattern delay test with arbitrary vectors. The sequence is:
1. Stage and apply the first vector.
2. Stage the second vector while the first is held.
3. Apply the second vector to launch the transition.
4. Capture the response.

Top module: `col_scan_array`

## Requirements
- R1: While reset is asserted, and until a write or capture occurs after reset, every shadow bit and every functional bit is 0. As a result, func_out is all zero, scan_out is all zero, and an apply issued right after reset leaves func_out all zero.
- R2: A cycle with scan_wr high and col_addr = c < N_COLS loads scan_in[r] into the shadow bit of cell (row r, column c) for every r. No shadow bit of any other column changes.
- R3: When col_addr >= N_COLS, a scan write changes no shadow bit, and scan_out is all zero.
- R4: scan_out[r] equals the functional bit of cell (r, col_addr) in the same cycle as the address is presented, with no clock edge needed.
- R5: Scan writes on their own never change func_out. The functional bits change only on apply or capture.
- R6: When apply is high and capture is low, every functional bit takes its cell's shadow bit at the next clock edge. A shadow write in the same cycle does not affect the value that is applied.
- R7: When capture is high, every functional bit takes its func_in bit at the next clock edge. Capture has priority over apply.
- R8: Bit c*N_CHAINS + r of func_in and func_out belongs to cell (r, c).
- R9: Two-pattern test: after vector V1 is applied, writing V2 into the shadow bits keeps V1 on func_out. A second apply then switches func_out from V1 to V2 in one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| col_addr | input | AW | Binary column address |
| scan_wr | input | 1 | Load scan_in into the shadow bits of the addressed column |
| scan_in | input | N_CHAINS | One scan-in bit per chain |
| scan_out | output | N_CHAINS | Functional bits of the addressed column |
| apply | input | 1 | Copy all shadow bits into the functional bits |
| capture | input | 1 | Load func_in into all functional bits |
| func_in | input | N_CHAINS*N_COLS | Response from the logic under test |
| func_out | output | N_CHAINS*N_COLS | Functional bits driving the logic under test |

## Verification
Each column is written with a different word that depends on its address, followed by a single apply. A bit that lands in the wrong column or the wrong row then shows up as a mismatch in func_out and in the readback. The shadow patterns are then rewritten without an apply, and func_out must not move; this separates the shadow bit from the functional bit. Writes to every out-of-range address, followed by an apply, show whether the decoder leaks. Captures with complementary patterns, captures together with apply, and a V1-to-V2 launch sequence check the priority rule and the two-vector behaviour.

// File: rtl/colscan_pkg.sv
package colscan_pkg;
  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/colscan_rst_sync.sv
module colscan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'b00;
    else        q <= {q[0], 1'b1};
  end
  assign rst_s = q[1];
endmodule

// File: rtl/colscan_decoder.sv
module colscan_decoder #(
  parameter int N_COLS = 5,
  parameter int AW     = 3
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  output logic [N_COLS-1:0] en
);
  // Only indices below N_COLS exist, so any address at or past the count
  // matches nothing and every enable stays low.
  for (genvar c = 0; c < N_COLS; c++) begin : g_en
    assign en[c] = wr && (addr == AW'(c));
  end
endmodule

// File: rtl/colscan_cell.sv
module colscan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sh_en,
  input  logic sh_d,
  input  logic apply,
  input  logic cap,
  input  logic cap_d,
  output logic sh_q,
  output logic fn_q
);
  logic sh_n, fn_n;

  always_comb begin
    sh_n = sh_en ? sh_d : sh_q;
    fn_n = fn_q;
    if (cap)        fn_n = cap_d;
    else if (apply) fn_n = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 1'b0;
      fn_q <= 1'b0;
    end else begin
      sh_q <= sh_n;
      fn_q <= fn_n;
    end
  end
endmodule

// File: rtl/colscan_read_mux.sv
module colscan_read_mux #(
  parameter int N_CHAINS = 4,
  parameter int N_COLS   = 5,
  parameter int AW       = 3
) (
  input  logic [N_CHAINS*N_COLS-1:0] fn_flat,
  input  logic [AW-1:0]              addr,
  output logic [N_CHAINS-1:0]        word
);
  always_comb begin
    word = '0;
    for (int c = 0; c < N_COLS; c++) begin
      if (addr == AW'(c)) word = fn_flat[c*N_CHAINS +: N_CHAINS];
    end
  end
endmodule

// File: rtl/col_scan_array.sv
module col_scan_array #(
  parameter int N_CHAINS = 4,
  parameter int N_COLS   = 5,
  parameter int AW       = colscan_pkg::addr_bits(N_COLS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                col_addr,
  input  logic                         scan_wr,
  input  logic [N_CHAINS-1:0]          scan_in,
  output logic [N_CHAINS-1:0]          scan_out,
  input  logic                         apply,
  input  logic                         capture,
  input  logic [N_CHAINS*N_COLS-1:0]   func_in,
  output logic [N_CHAINS*N_COLS-1:0]   func_out
);
  localparam int NBITS = N_CHAINS * N_COLS;

  logic              rst_s;
  logic [N_COLS-1:0] col_en;
  logic [NBITS-1:0]  shadow_flat;
  logic [NBITS-1:0]  func_flat;

  colscan_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  colscan_decoder #(.N_COLS(N_COLS), .AW(AW)) u_dec (
    .addr(col_addr), .wr(scan_wr), .en(col_en)
  );

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    for (genvar r = 0; r < N_CHAINS; r++) begin : g_row
      colscan_cell u_cell (
        .clk   (clk),
        .rst_n (rst_s),
        .sh_en (col_en[c]),
        .sh_d  (scan_in[r]),
        .apply (apply),
        .cap   (capture),
        .cap_d (func_in[c*N_CHAINS + r]),
        .sh_q  (shadow_flat[c*N_CHAINS + r]),
        .fn_q  (func_flat[c*N_CHAINS + r])
      );
    end
  end

  colscan_read_mux #(.N_CHAINS(N_CHAINS), .N_COLS(N_COLS), .AW(AW)) u_rd (
    .fn_flat(func_flat), .addr(col_addr), .word(scan_out)
  );

  assign func_out = func_flat;
endmodule

// File: rtl/colscan_chk.sv
module colscan_chk #(
  parameter int N_CHAINS = 4,
  parameter int N_COLS   = 5,
  parameter int AW       = 3
) (
  input logic                       clk,
  input logic                       rst_s,
  input logic                       scan_wr,
  input logic [AW-1:0]              col_addr,
  input logic                       apply,
  input logic                       capture,
  input logic [N_COLS-1:0]          col_en,
  input logic [N_CHAINS*N_COLS-1:0] shadow_flat,
  input logic [N_CHAINS*N_COLS-1:0] func_flat,
  input logic [N_CHAINS*N_COLS-1:0] func_in
);
  logic oob;
  assign oob = ({{(32-AW){1'b0}}, col_addr} >= 32'(N_COLS));

  // R2: at most one column enabled at a time
  a_r2_one_column: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(col_en));

  // R3: out-of-range address enables nothing
  a_r3_no_oob_enable: assert property (@(posedge clk) disable iff (!rst_s)
    oob |-> (col_en == '0));

  // R2: a column without its enable holds its shadow bits
  for (genvar c = 0; c < N_COLS; c++) begin : g_hold
    a_r2_hold_col: assert property (@(posedge clk) disable iff (!rst_s)
      !col_en[c] |=> $stable(shadow_flat[c*N_CHAINS +: N_CHAINS]));
  end

  // R5: functional bits move only on apply or capture
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_s)
    (!apply && !capture) |=> $stable(func_flat));

  // R6: apply copies shadow into functional bits
  a_r6_apply: assert property (@(posedge clk) disable iff (!rst_s)
    (apply && !capture) |=> (func_flat == $past(shadow_flat)));

  // R7: capture loads the response, ahead of apply
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_s)
    capture |=> (func_flat == $past(func_in)));
endmodule

bind col_scan_array colscan_chk #(.N_CHAINS(N_CHAINS), .N_COLS(N_COLS), .AW(AW)) u_chk (
  .clk(clk), .rst_s(rst_s), .scan_wr(scan_wr), .col_addr(col_addr),
  .apply(apply), .capture(capture), .col_en(col_en),
  .shadow_flat(shadow_flat), .func_flat(func_flat), .func_in(func_in)
);

// File: tb/sim_col_scan_array.sv
`timescale 1ns/1ps
module sim_col_scan_array;
  localparam int NC = 4;
  localparam int NK = 5;
  localparam int AW = 3;
  localparam int NB = NC * NK;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] col_addr;
  logic scan_wr, apply, capture;
  logic [NC-1:0] scan_in, scan_out;
  logic [NB-1:0] func_in, func_out;

  int checks = 0;
  int errors = 0;
  logic [NC-1:0] msh [NK];
  logic [NC-1:0] mfn [NK];

  always #2 clk = ~clk;

  col_scan_array #(.N_CHAINS(NC), .N_COLS(NK)) u0 (
    .clk(clk), .rst_n(rst_n), .col_addr(col_addr), .scan_wr(scan_wr),
    .scan_in(scan_in), .scan_out(scan_out), .apply(apply),
    .capture(capture), .func_in(func_in), .func_out(func_out)
  );

  function automatic logic [NB-1:0] flat_fn();
    logic [NB-1:0] v;
    for (int c = 0; c < NK; c++) v[c*NC +: NC] = mfn[c];
    return v;
  endfunction

  function automatic logic [NC-1:0] pat(input int c, input int k);
    return NC'((c * 5 + k * 3 + 1) ^ (k << 1));
  endfunction

  task automatic cyc(input logic wr, input int addr, input logic [NC-1:0] din,
                     input logic ap, input logic cp, input logic [NB-1:0] fin);
    @(negedge clk);
    scan_wr = wr; col_addr = AW'(addr); scan_in = din;
    apply = ap; capture = cp; func_in = fin;
    @(posedge clk);
    if (cp) begin
      for (int c = 0; c < NK; c++) mfn[c] = fin[c*NC +: NC];
    end else if (ap) begin
      for (int c = 0; c < NK; c++) mfn[c] = msh[c];
    end
    if (wr && addr < NK) msh[addr] = din;
    @(negedge clk);
    scan_wr = 0; apply = 0; capture = 0;
  endtask

  task automatic chk_fn(input string req);
    checks++;
    if (func_out !== flat_fn()) begin
      errors++;
      $display("FAIL %s func_out actual=%h expected=%h", req, func_out, flat_fn());
    end
  endtask

  task automatic chk_rd(input int addr, input string req);
    logic [NC-1:0] exp;
    col_addr = AW'(addr);
    #0.5;
    exp = (addr < NK) ? mfn[addr] : '0;
    checks++;
    if (scan_out !== exp) begin
      errors++;
      $display("FAIL %s scan_out addr=%0d actual=%h expected=%h", req, addr, scan_out, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; scan_wr = 0; apply = 0; capture = 0;
    col_addr = '0; scan_in = '0; func_in = '0;
    for (int c = 0; c < NK; c++) begin msh[c] = '0; mfn[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_fn("R1");
    for (int a = 0; a < NK; a++) chk_rd(a, "R1");
    cyc(0, 0, '0, 1, 0, '0);
    chk_fn("R1 apply-after-reset");

    // R2/R8: write each column, apply, check whole array
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < NK; c++) cyc(1, c, pat(c, k), 0, 0, '0);
      chk_fn("R5 writes-no-effect");
      cyc(0, 0, '0, 1, 0, '0);
      chk_fn("R2 R8 R6 apply");
      for (int a = 0; a < (1 << AW); a++) chk_rd(a, "R4 R3 readback");
    end

    // R3: out-of-range writes change nothing
    for (int a = NK; a < (1 << AW); a++) cyc(1, a, 4'hF, 0, 0, '0);
    cyc(0, 0, '0, 1, 0, '0);
    chk_fn("R3 oob-write");

    // R6: write during apply does not affect applied value
    cyc(1, 2, ~msh[2], 1, 0, '0);
    chk_fn("R6 same-cycle write");
    cyc(0, 0, '0, 1, 0, '0);
    chk_fn("R6 later apply");

    // R7: capture, and priority over apply
    cyc(0, 0, '0, 0, 1, 20'hA5C3E);
    chk_fn("R7 capture");
    for (int a = 0; a < NK; a++) chk_rd(a, "R7 R4 read-capture");
    cyc(0, 0, '0, 1, 1, 20'h5A3C1);
    chk_fn("R7 priority");
    cyc(1, 1, 4'h6, 0, 1, ~20'h5A3C1);
    chk_fn("R7 capture-with-write");

    // R9: two-pattern launch
    for (int c = 0; c < NK; c++) cyc(1, c, NC'(c), 0, 0, '0);
    cyc(0, 0, '0, 1, 0, '0);
    chk_fn("R9 V1 applied");
    for (int c = 0; c < NK; c++) cyc(1, c, ~NC'(c), 0, 0, '0);
    chk_fn("R9 V1 held");
    cyc(0, 0, '0, 1, 0, '0);
    chk_fn("R9 V2 launched");
    for (int a = 0; a < NK; a++) chk_rd(a, "R9 read V2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule